// File: doc/BRIEF.md
# Serial Flash Read Command Front End

This block is the target-side command interface of a serial NOR flash model, restricted to the commands that read. A host selects it by pulling `cs_n` low and clocks in an 8-bit command code and, for addressed reads, a 24-bit start address. Both arrive most significant bit first on `si` and are sampled on rising `sck`. The block then keeps shifting out bytes from a small behavioural array for as long as the host keeps clocking. The array address advances on its own after each byte.

Several read commands are decoded. Plain reads use one output lane. Fast reads insert 8 or 16 dummy clocks before the data. Wide reads put 2 or 4 bits on the lanes per clock, and the 4-lane read is only recognised while `quad_en` is high. A status read streams an externally supplied status byte. A sleep command puts the block into deep power-down, and in that state only the wake command is recognised.

The design runs on a system clock that is much faster than `sck`. Every pin is sampled on that clock, and serial clock edges are found by comparing `sck` with its value one cycle earlier. Output lanes change only when a falling `sck` edge is seen, so the interface works in SPI mode 0.

Top module: `sflash_read_port`

## Requirements
- R1: Command bytes and the 24 address bits are captured MSB first from `si` on rising `sck` edges while `cs_n` is low. Output lanes change only after a falling `sck` edge.
- R2: Command 03h has no dummy clocks. The first data bit appears on `io_out[1]` after the falling edge that follows the 32nd rising edge. `io_oe` is 4'b0010.
- R3: Command 0Bh inserts 8 dummy clocks between the last address bit and the first data bit. Command 1Bh inserts 16.
- R4: Data streams continuously while clocking goes on. The array address increments by one after each byte and wraps from DEPTH-1 to 0. The start address is the 24-bit address modulo DEPTH.
- R5: While `cs_n` is high, `io_oe` is 0 and `si` and `sck` have no effect. Raising `cs_n` at any point aborts the command, and the next selection starts again with a fresh command byte.
- R6: Command 3Bh uses 8 dummy clocks and 2 bits per clock. The higher bit of each pair is on `io_out[1]` and the lower on `io_out[0]`. `io_oe` is 4'b0011.
- R7: Command 6Bh is recognised only while `quad_en` is 1. It uses 8 dummy clocks and 4 bits per clock: bits 7..4 on `io_out[3:0]`, then bits 3..0. `io_oe` is 4'b1111. While `quad_en` is 0, this command produces no output.
- R8: Command 05h has no address and no dummy clocks. It streams `status_in` MSB first on `io_out[1]`, reloading it at every byte boundary. It is accepted whatever the busy bit (bit 0) holds.
- R9: Command B9h puts the block into deep power-down when `cs_n` rises. In that state only command ABh is recognised. ABh returns the block to standby, and every bit clocked after it in the same selection is ignored.
- R10: An unrecognised command code drives no output until `cs_n` rises.
- R11: After reset, the array byte at address a is (a*37 + 92) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sck` |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial command and address input |
| quad_en | input | 1 | Enables the 4-lane read command |
| status_in | input | 8 | Status byte returned by the status read |
| io_out | output | 4 | Output lane values |
| io_oe | output | 4 | Per-lane output enables |

## Verification
The bound checker watches four things on every system cycle:
- the lanes are released whenever the block is deselected;
- the output-enable pattern is always one of the four legal shapes;
- the 4-lane pattern never appears without `quad_en`;
- outputs change only after a detected falling serial edge, and stay silent during deep power-down.

Some behaviour can only be shown by the bench's directed scenarios, because it depends on the data content and on the exact clock count:
- the dummy-clock count of each command;
- the byte values and the lane order;
- address wrap-around;
- the abort, unknown-command and wake-then-ignore sequences.

// File: rtl/sflash_read_port.sv
module sflash_read_port #(
  parameter int DEPTH      = 256,
  parameter int FAST_DUMMY = 8,
  parameter int SLOW_DUMMY = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       si,
  input  logic       quad_en,
  input  logic [7:0] status_in,
  output logic [3:0] io_out,
  output logic [3:0] io_oe
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int MAXD = (SLOW_DUMMY > FAST_DUMMY) ? SLOW_DUMMY : FAST_DUMMY;
  localparam int CW = $clog2(MAXD + 32);
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_FAST   = 8'h0B;
  localparam logic [7:0] OP_SLOW   = 8'h1B;
  localparam logic [7:0] OP_DUAL   = 8'h3B;
  localparam logic [7:0] OP_QUAD   = 8'h6B;
  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] OP_SLEEP  = 8'hB9;
  localparam logic [7:0] OP_WAKE   = 8'hAB;

  typedef enum logic [2:0] {S_OP, S_ADDR, S_DUMMY, S_DATA, S_SKIP} st_t;

  st_t           st;
  logic          sck_q;
  logic [CW-1:0] cnt;
  logic [6:0]    op_sh;
  logic [22:0]   addr_sh;
  logic [AW-1:0] ptr;
  logic [2:0]    lanes;
  logic [CW-1:0] dummy_n;
  logic          from_status;
  logic [7:0]    sh;
  logic [3:0]    left;
  logic          dpd, dpd_arm;
  logic [7:0]    mem [DEPTH];

  wire rise = ~cs_n & sck & ~sck_q;
  wire fall = ~cs_n & ~sck & sck_q;
  wire [7:0]  opcode    = {op_sh, si};
  wire [23:0] addr_full = {addr_sh, si};
  wire [7:0]  src       = from_status ? status_in : mem[ptr];

  logic          dec_ok, dec_addr;
  logic [2:0]    dec_lanes;
  logic [CW-1:0] dec_dummy;

  always_comb begin
    dec_ok    = 1'b1;
    dec_addr  = 1'b1;
    dec_lanes = 3'd1;
    dec_dummy = '0;
    case (opcode)
      OP_READ:   ;
      OP_FAST:   dec_dummy = CW'(FAST_DUMMY);
      OP_SLOW:   dec_dummy = CW'(SLOW_DUMMY);
      OP_DUAL:   begin dec_lanes = 3'd2; dec_dummy = CW'(FAST_DUMMY); end
      OP_QUAD:   begin dec_lanes = 3'd4; dec_dummy = CW'(FAST_DUMMY); dec_ok = quad_en; end
      OP_STATUS: dec_addr = 1'b0;
      default:   dec_ok = 1'b0;
    endcase
  end

  function automatic logic [3:0] lane_bits(input logic [7:0] b, input logic [2:0] n);
    case (n)
      3'd4:    return b[7:4];
      3'd2:    return {2'b00, b[7], b[6]};
      default: return {2'b00, b[7], 1'b0};
    endcase
  endfunction

  function automatic logic [3:0] lane_oe(input logic [2:0] n);
    case (n)
      3'd4:    return 4'b1111;
      3'd2:    return 4'b0011;
      default: return 4'b0010;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_OP;
      sck_q       <= 1'b0;
      cnt         <= '0;
      op_sh       <= '0;
      addr_sh     <= '0;
      ptr         <= '0;
      lanes       <= 3'd1;
      dummy_n     <= '0;
      from_status <= 1'b0;
      sh          <= '0;
      left        <= '0;
      dpd         <= 1'b0;
      dpd_arm     <= 1'b0;
      io_out      <= '0;
      io_oe       <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'(i * 37 + 92);
    end else begin
      sck_q <= sck;
      if (cs_n) begin
        st    <= S_OP;
        cnt   <= '0;
        io_oe <= '0;
        if (dpd_arm) begin
          dpd     <= 1'b1;
          dpd_arm <= 1'b0;
        end
      end else if (rise) begin
        case (st)
          S_OP: begin
            op_sh <= opcode[6:0];
            cnt   <= cnt + 1'b1;
            if (cnt == CW'(7)) begin
              cnt <= '0;
              if (dpd) begin
                st <= S_SKIP;
                if (opcode == OP_WAKE) dpd <= 1'b0;
              end else if (opcode == OP_SLEEP) begin
                st      <= S_SKIP;
                dpd_arm <= 1'b1;
              end else if (dec_ok) begin
                lanes       <= dec_lanes;
                dummy_n     <= dec_dummy;
                from_status <= ~dec_addr;
                left        <= '0;
                st          <= dec_addr ? S_ADDR : S_DATA;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          S_ADDR: begin
            addr_sh <= addr_full[22:0];
            cnt     <= cnt + 1'b1;
            if (cnt == CW'(23)) begin
              cnt <= '0;
              ptr <= AW'(addr_full % DEPTH);
              st  <= (dummy_n == '0) ? S_DATA : S_DUMMY;
            end
          end
          S_DUMMY: begin
            cnt <= cnt + 1'b1;
            if (cnt == dummy_n - 1'b1) st <= S_DATA;
          end
          default: ;
        endcase
      end else if (fall && st == S_DATA) begin
        if (left == '0) begin
          io_out <= lane_bits(src, lanes);
          io_oe  <= lane_oe(lanes);
          sh     <= src << lanes;
          left   <= 4'd8 - {1'b0, lanes};
          if (!from_status) ptr <= (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
        end else begin
          io_out <= lane_bits(sh, lanes);
          sh     <= sh << lanes;
          left   <= left - {1'b0, lanes};
        end
      end
    end
  end
endmodule

module sflash_read_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sck,
  input logic       quad_en,
  input logic       dpd,
  input logic [3:0] io_out,
  input logic [3:0] io_oe
);
  logic sck_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck;

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> io_oe == 4'b0000); // R5
  AST_OE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'b0000 || io_oe == 4'b0010 || io_oe == 4'b0011 || io_oe == 4'b1111)); // R6
  AST_QUAD_GATED: assert property (@(posedge clk) disable iff (!rst_n) io_oe == 4'b1111 |-> quad_en); // R7
  AST_SHIFT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) !(sck_d && !sck) |=> $stable(io_out)); // R1
  AST_SLEEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n) dpd |-> io_oe == 4'b0000); // R9
endmodule

bind sflash_read_port sflash_read_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .quad_en(quad_en),
  .dpd(dpd), .io_out(io_out), .io_oe(io_oe)
);

// File: tb/sflash_read_port_test.sv
module sflash_read_port_test;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, quad_en = 1'b0;
  logic [7:0] status_in = 8'h00;
  wire  [3:0] io_out, io_oe;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sflash_read_port uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .quad_en(quad_en),
    .status_in(status_in), .io_out(io_out), .io_oe(io_oe)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a % 256) * 37 + 92);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic clk_bit(input logic d, output logic [3:0] q, output logic [3:0] oe);
    si = d;
    half();
    q  = io_out;
    oe = io_oe;
    sck = 1'b1;
    half();
    sck = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic [3:0] q, oe;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], q, oe);
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [3:0] q, oe;
    for (int i = 23; i >= 0; i--) clk_bit(a[i], q, oe);
  endtask

  task automatic dummies(input int n);
    logic [3:0] q, oe;
    for (int i = 0; i < n; i++) clk_bit(1'b0, q, oe);
  endtask

  task automatic read_byte(input int lanes, output logic [7:0] b, output logic [3:0] oe0);
    logic [3:0] q, oe;
    b = '0;
    for (int i = 0; i < 8 / lanes; i++) begin
      clk_bit(1'b0, q, oe);
      if (i == 0) oe0 = oe;
      case (lanes)
        4:       b = {b[3:0], q};
        2:       b = {b[5:0], q[1], q[0]};
        default: b = {b[6:0], q[1]};
      endcase
    end
  endtask

  task automatic scan(input int n, output int seen);
    logic [3:0] q, oe;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      clk_bit(1'b0, q, oe);
      if (oe != 4'b0000) seen++;
    end
  endtask

  task automatic begin_cmd();
    cs_n = 1'b0;
    half();
  endtask

  task automatic end_cmd();
    half();
    cs_n = 1'b1;
    half();
    half();
  endtask

  task automatic t_reset();
    chk(io_oe == 4'b0000, "R5 reset oe", io_oe, 0);
  endtask

  task automatic t_plain();
    logic [7:0] b; logic [3:0] oe0;
    begin_cmd(); send_byte(8'h03); send_addr(24'h000010);
    read_byte(1, b, oe0);
    chk(oe0 == 4'b0010, "R2 single-lane oe", oe0, 4'b0010);
    chk(b == pat(16), "R1 R11 first byte", b, pat(16));
    for (int k = 1; k < 3; k++) begin
      read_byte(1, b, oe0);
      chk(b == pat(16 + k), "R4 stream byte", b, pat(16 + k));
    end
    end_cmd();
  endtask

  task automatic t_fast_wrap();
    logic [7:0] b; logic [3:0] oe0;
    begin_cmd(); send_byte(8'h0B); send_addr(24'h1234FE); dummies(8);
    for (int k = 0; k < 3; k++) begin
      read_byte(1, b, oe0);
      chk(b == pat((254 + k) % 256), "R3 R4 fast read wrap", b, pat((254 + k) % 256));
    end
    end_cmd();
  endtask

  task automatic t_slow();
    logic [7:0] b; logic [3:0] oe0;
    begin_cmd(); send_byte(8'h1B); send_addr(24'h000040); dummies(16);
    for (int k = 0; k < 2; k++) begin
      read_byte(1, b, oe0);
      chk(b == pat(64 + k), "R3 sixteen dummy", b, pat(64 + k));
    end
    end_cmd();
  endtask

  task automatic t_dual();
    logic [7:0] b; logic [3:0] oe0;
    begin_cmd(); send_byte(8'h3B); send_addr(24'h000020); dummies(8);
    read_byte(2, b, oe0);
    chk(oe0 == 4'b0011, "R6 dual oe", oe0, 4'b0011);
    chk(b == pat(32), "R6 dual byte0", b, pat(32));
    read_byte(2, b, oe0);
    chk(b == pat(33), "R6 dual byte1", b, pat(33));
    end_cmd();
  endtask

  task automatic t_quad();
    logic [7:0] b; logic [3:0] oe0; int seen;
    quad_en = 1'b1;
    begin_cmd(); send_byte(8'h6B); send_addr(24'h000080); dummies(8);
    read_byte(4, b, oe0);
    chk(oe0 == 4'b1111, "R7 quad oe", oe0, 4'b1111);
    chk(b == pat(128), "R7 quad byte0", b, pat(128));
    for (int k = 1; k < 3; k++) begin
      read_byte(4, b, oe0);
      chk(b == pat(128 + k), "R7 quad stream", b, pat(128 + k));
    end
    end_cmd();
    quad_en = 1'b0;
    begin_cmd(); send_byte(8'h6B); send_addr(24'h000080); scan(24, seen); end_cmd();
    chk(seen == 0, "R7 quad disabled silent", seen, 0);
  endtask

  task automatic t_status();
    logic [7:0] b; logic [3:0] oe0;
    status_in = 8'h83;
    begin_cmd(); send_byte(8'h05);
    read_byte(1, b, oe0);
    chk(b == 8'h83 && oe0 == 4'b0010, "R8 status while busy", b, 8'h83);
    read_byte(1, b, oe0);
    chk(b == 8'h83, "R8 status repeat", b, 8'h83);
    status_in = 8'h02;
    read_byte(1, b, oe0);
    chk(b == 8'h02, "R8 status reload", b, 8'h02);
    end_cmd();
  endtask

  task automatic t_abort();
    logic [7:0] b; logic [3:0] oe0, q, oe; int seen;
    begin_cmd(); send_byte(8'h03);
    for (int i = 0; i < 12; i++) clk_bit(1'b1, q, oe);
    end_cmd();
    chk(io_oe == 4'b0000, "R5 abort released", io_oe, 0);
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      clk_bit(1'b1, q, oe);
      if (oe != 4'b0000) seen++;
    end
    chk(seen == 0, "R5 deselected clocks", seen, 0);
    begin_cmd(); send_byte(8'h03); send_addr(24'h000005);
    read_byte(1, b, oe0);
    chk(b == pat(5), "R5 fresh command after abort", b, pat(5));
    end_cmd();
  endtask

  task automatic t_unknown();
    int seen;
    begin_cmd(); send_byte(8'h5A); scan(40, seen); end_cmd();
    chk(seen == 0, "R10 unknown code silent", seen, 0);
  endtask

  task automatic t_sleep();
    logic [7:0] b; logic [3:0] oe0; int seen;
    begin_cmd(); send_byte(8'hB9); end_cmd();
    begin_cmd(); send_byte(8'h03); send_addr(24'h000000); scan(16, seen); end_cmd();
    chk(seen == 0, "R9 read ignored asleep", seen, 0);
    begin_cmd(); send_byte(8'hAB); send_byte(8'h03); send_addr(24'h000000); scan(16, seen); end_cmd();
    chk(seen == 0, "R9 bits after wake ignored", seen, 0);
    begin_cmd(); send_byte(8'h03); send_addr(24'h000007);
    read_byte(1, b, oe0);
    chk(b == pat(7), "R9 awake read", b, pat(7));
    end_cmd();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    half();
    t_reset();
    t_plain();
    t_fast_wrap();
    t_slow();
    t_dual();
    t_quad();
    t_status();
    t_abort();
    t_unknown();
    t_sleep();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule